// File: doc/BRIEF.md
# Six-Step Inverter Gate Sequencer

This block produces the six gate commands of a three-phase half-bridge inverter using six-step commutation. A single-cycle step pulse, running on the system clock, moves a mod-6 sector counter forward by one sector. The pulse rate therefore sets the electrical frequency. A combinational decoder maps the current sector to a command for each of the three legs: drive high, drive low, or float.

Two commutation patterns come from the same counter. In the full-conduction pattern every leg is always driven one way or the other. In the two-switch pattern one leg floats in each sector. Each leg command passes through its own dead-time stage. Whenever a leg reverses direction, that stage holds both of the leg's switches off for a programmable number of cycles. A chopping input gates only the high-side outputs, which varies the applied voltage. A run input blanks all six gates at once.

Top module: `sixstep_gate_seq`

## Requirements
- R1: The internal sector counter starts at 0 after reset. It advances by one on each clock edge where `step_en` and `run_en` are both 1, and holds on every other edge.
- R2: A step taken in sector 5 returns the counter to sector 0.
- R3: With `mode_sel`=0 (full conduction), leg A drives high in sectors 0, 4 and 5. Leg B drives high in sectors 1, 2 and 0. Leg C drives high in sectors 3, 4 and 2. In every other sector each leg drives its low side. Bit 0 of each gate bus is leg A, bit 1 is leg B and bit 2 is leg C.
- R4: With `mode_sel`=1 (two-switch), the high sides conduct as follows: A in sectors 0 and 1, B in sectors 2 and 3, C in sectors 4 and 5. The low sides conduct as follows: C in sectors 1 and 2, A in sectors 3 and 4, B in sectors 5 and 0. A leg that is not listed for a sector has both of its gates at 0.
- R5: The gate outputs reflect a new sector one clock edge after the edge that took the step.
- R6: When a leg's command reverses direction (high to low, or low to high), both gates of that leg stay at 0 for exactly `dead_cycles` cycles before the new side turns on. With `dead_cycles`=0 the swap takes place in a single edge. Moving to or from the floating state adds no delay.
- R7: When `pwm_in` is 0, all `gate_hi` bits are 0 in the same cycle. `gate_lo` is unaffected by `pwm_in`.
- R8: When `run_en` is 0, all six gates are 0 in the same cycle and the sector counter holds. On the first edge after `run_en` returns to 1, the gates take the current sector's pattern with no dead time.
- R9: A change on `mode_sel` takes effect only on an edge that advances the sector (or while `run_en` is 0). Between such edges the pattern in use does not change.
- R10: While `rst_n` is 0, all gates are 0. Reset selects sector 0 in the full-conduction pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_en | input | 1 | Run enable; 0 blanks all gates and freezes the counter |
| step_en | input | 1 | Single-cycle sector advance pulse |
| mode_sel | input | 1 | Pattern select: 0 full conduction, 1 two-switch |
| pwm_in | input | 1 | Chopping input applied to the high-side gates only |
| dead_cycles | input | DT_W | Direction-reversal blanking time, in clock cycles |
| gate_hi | output | 3 | High-side gate commands, bit 0 leg A, bit 2 leg C |
| gate_lo | output | 3 | Low-side gate commands, bit 0 leg A, bit 2 leg C |

## Verification
A step pulse sampled at edge k changes the sector at edge k. The leg stage registers the new command at edge k+1, so the bench checks sector results two falling edges after it raises `step_en`. A reversing leg stays blank from edge k+1 through edge k+`dead_cycles`. It turns on at edge k+1+`dead_cycles`, and the bench samples in the last blank cycle and in the first cycle after it. `pwm_in` and `run_en` act combinationally on the outputs, so they are checked at the next falling edge after they change. Counter hold under `run_en`=0 is observed at the ports: the bench compares the restarted pattern with the sector that was active before the pause.

// File: rtl/sixstep_pkg.sv
package sixstep_pkg;
  localparam int NUM_STEPS = 6;
  localparam int NUM_LEGS  = 3;
  localparam int STEP_W    = 3;

  typedef logic [STEP_W-1:0] step_t;

  // Command presented to one half-bridge leg
  typedef enum logic [1:0] {
    LEG_OFF = 2'b00,
    LEG_HI  = 2'b01,
    LEG_LO  = 2'b10
  } leg_cmd_t;
endpackage

// File: rtl/sixstep_rst_sync.sv
module sixstep_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_n_sync <= meta_q;
    end
  end
endmodule

// File: rtl/sixstep_sector_ctr.sv
module sixstep_sector_ctr
  import sixstep_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run_en,
  input  logic  step_en,
  input  logic  mode_sel,
  output step_t sector,
  output logic  mode_q
);
  localparam step_t LAST_STEP = step_t'(NUM_STEPS - 1);

  logic  advance;
  logic  mode_ld;
  step_t sector_nx;
  logic  mode_nx;

  assign advance = step_en & run_en;
  assign mode_ld = advance | ~run_en;

  always_comb begin
    sector_nx = sector;
    mode_nx   = mode_q;
    if (advance) begin
      sector_nx = (sector == LAST_STEP) ? '0 : sector + step_t'(1);
    end
    if (mode_ld) begin
      mode_nx = mode_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sector <= '0;
      mode_q <= 1'b0;
    end else begin
      sector <= sector_nx;
      mode_q <= mode_nx;
    end
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && sector == LAST_STEP) |=> (sector == '0)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance) |=> $stable(sector)); // R1
  AST_SECTOR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (sector <= LAST_STEP)); // R1
  AST_MODE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !step_en) |=> $stable(mode_q)); // R9
endmodule

// File: rtl/sixstep_decode.sv
module sixstep_decode
  import sixstep_pkg::*;
(
  input  step_t                     sector,
  input  logic                      mode_q,
  output leg_cmd_t [NUM_LEGS-1:0]   leg_cmd
);
  logic [NUM_LEGS-1:0] hi_mask;
  logic [NUM_LEGS-1:0] lo_mask;

  // Masks are ordered {C, B, A}
  always_comb begin
    hi_mask = '0;
    lo_mask = '0;
    if (!mode_q) begin
      case (sector)
        3'd0:    hi_mask = 3'b011;
        3'd1:    hi_mask = 3'b010;
        3'd2:    hi_mask = 3'b110;
        3'd3:    hi_mask = 3'b100;
        3'd4:    hi_mask = 3'b101;
        default: hi_mask = 3'b001;
      endcase
      lo_mask = ~hi_mask;
    end else begin
      case (sector)
        3'd0:    begin hi_mask = 3'b001; lo_mask = 3'b010; end
        3'd1:    begin hi_mask = 3'b001; lo_mask = 3'b100; end
        3'd2:    begin hi_mask = 3'b010; lo_mask = 3'b100; end
        3'd3:    begin hi_mask = 3'b010; lo_mask = 3'b001; end
        3'd4:    begin hi_mask = 3'b100; lo_mask = 3'b001; end
        default: begin hi_mask = 3'b100; lo_mask = 3'b010; end
      endcase
    end
  end

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    assign leg_cmd[g] = hi_mask[g] ? LEG_HI : (lo_mask[g] ? LEG_LO : LEG_OFF);
  end
endmodule

// File: rtl/sixstep_dead_leg.sv
module sixstep_dead_leg
  import sixstep_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_en,
  input  logic [DT_W-1:0] dead_cycles,
  input  leg_cmd_t        target,
  output leg_cmd_t        applied
);
  localparam logic [DT_W-1:0] CNT_ONE = DT_W'(1);

  logic [DT_W-1:0] cnt_q;
  logic [DT_W-1:0] cnt_nx;
  leg_cmd_t        app_nx;

  always_comb begin
    app_nx = applied;
    cnt_nx = cnt_q;
    if (!run_en || target == LEG_OFF) begin
      app_nx = LEG_OFF;
      cnt_nx = '0;
    end else if (applied == LEG_OFF) begin
      if (cnt_q == '0) begin
        app_nx = target;
      end else begin
        cnt_nx = cnt_q - CNT_ONE;
      end
    end else if (applied != target) begin
      if (dead_cycles == '0) begin
        app_nx = target;
      end else begin
        app_nx = LEG_OFF;
        cnt_nx = dead_cycles - CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      applied <= LEG_OFF;
      cnt_q   <= '0;
    end else begin
      applied <= app_nx;
      cnt_q   <= cnt_nx;
    end
  end

  AST_NO_DIRECT_FLIP_HL: assert property (@(posedge clk) disable iff (!rst_n)
    (applied == LEG_HI && dead_cycles != '0) |=> (applied != LEG_LO)); // R6
  AST_NO_DIRECT_FLIP_LH: assert property (@(posedge clk) disable iff (!rst_n)
    (applied == LEG_LO && dead_cycles != '0) |=> (applied != LEG_HI)); // R6
endmodule

// File: rtl/sixstep_gate_seq.sv
module sixstep_gate_seq
  import sixstep_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_en,
  input  logic                step_en,
  input  logic                mode_sel,
  input  logic                pwm_in,
  input  logic [DT_W-1:0]     dead_cycles,
  output logic [NUM_LEGS-1:0] gate_hi,
  output logic [NUM_LEGS-1:0] gate_lo
);
  logic                    rst_n_s;
  step_t                   sector;
  logic                    mode_q;
  leg_cmd_t [NUM_LEGS-1:0] leg_cmd;
  leg_cmd_t [NUM_LEGS-1:0] leg_app;

  sixstep_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  sixstep_sector_ctr u_ctr (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .run_en   (run_en),
    .step_en  (step_en),
    .mode_sel (mode_sel),
    .sector   (sector),
    .mode_q   (mode_q)
  );

  sixstep_decode u_dec (
    .sector  (sector),
    .mode_q  (mode_q),
    .leg_cmd (leg_cmd)
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    sixstep_dead_leg #(.DT_W(DT_W)) u_leg (
      .clk         (clk),
      .rst_n       (rst_n_s),
      .run_en      (run_en),
      .dead_cycles (dead_cycles),
      .target      (leg_cmd[g]),
      .applied     (leg_app[g])
    );
    assign gate_hi[g] = run_en & pwm_in & (leg_app[g] == LEG_HI);
    assign gate_lo[g] = run_en & (leg_app[g] == LEG_LO);
  end

  AST_RUN_BLANKS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!run_en) |-> (gate_hi == '0 && gate_lo == '0)); // R8
  AST_PWM_HIGH_ONLY: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!pwm_in) |-> (gate_hi == '0)); // R7
  AST_LEG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((gate_hi & gate_lo) == '0)); // R6
endmodule

// File: tb/sixstep_gate_seq_tb.sv
`timescale 1ns/1ps
module sixstep_gate_seq_tb_top;
  logic       clk;
  logic       rst_n;
  logic       run_en;
  logic       step_en;
  logic       mode_sel;
  logic       pwm_in;
  logic [7:0] dead_cycles;
  logic [2:0] gate_hi;
  logic [2:0] gate_lo;

  int n_cmp = 0;
  int n_bad = 0;

  // {mode applied at the step, expected gate_hi, expected gate_lo}
  localparam logic [6:0] VEC [12] = '{
    {1'b0, 3'b010, 3'b101},  // 180: sector 1
    {1'b0, 3'b110, 3'b001},  // 180: sector 2
    {1'b0, 3'b100, 3'b011},  // 180: sector 3
    {1'b0, 3'b101, 3'b010},  // 180: sector 4
    {1'b0, 3'b001, 3'b110},  // 180: sector 5
    {1'b0, 3'b011, 3'b100},  // 180: wrap to sector 0
    {1'b1, 3'b001, 3'b100},  // 120: sector 1
    {1'b1, 3'b010, 3'b100},  // 120: sector 2
    {1'b1, 3'b010, 3'b001},  // 120: sector 3
    {1'b1, 3'b100, 3'b001},  // 120: sector 4
    {1'b1, 3'b100, 3'b010},  // 120: sector 5
    {1'b1, 3'b001, 3'b010}   // 120: wrap to sector 0
  };

  sixstep_gate_seq dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_en      (run_en),
    .step_en     (step_en),
    .mode_sel    (mode_sel),
    .pwm_in      (pwm_in),
    .dead_cycles (dead_cycles),
    .gate_hi     (gate_hi),
    .gate_lo     (gate_lo)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [2:0] ehi, input logic [2:0] elo);
    n_cmp++;
    if (gate_hi !== ehi || gate_lo !== elo) begin
      n_bad++;
      $display("FAIL %s: got hi=%b lo=%b, expected hi=%b lo=%b", req, gate_hi, gate_lo, ehi, elo);
    end
  endtask

  // Pulse step_en for one cycle, leave the bench on the negedge after the output edge
  task automatic step_once();
    @(negedge clk) step_en = 1'b1;
    @(negedge clk) step_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; run_en = 1'b1; step_en = 1'b0; mode_sel = 1'b0;
    pwm_in = 1'b1; dead_cycles = 8'd0;
    repeat (3) @(negedge clk);
    check("R10 gates off in reset", 3'b000, 3'b000);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R10 sector 0 full conduction", 3'b011, 3'b100);

    // R1 R2 R3 R4 R5: table walk
    for (int i = 0; i < 12; i++) begin
      mode_sel = VEC[i][6];
      step_once();
      check($sformatf("R1 R2 R3 R4 R5 vector %0d", i), VEC[i][5:3], VEC[i][2:0]);
    end

    // R9: mode change without a step has no effect
    mode_sel = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 mode held mid-sector", 3'b001, 3'b010);
    step_once();
    check("R9 mode taken at step", 3'b010, 3'b101);

    // R6: leg C reverses low to high with 3 cycles of blanking
    dead_cycles = 8'd3;
    step_once();
    check("R6 leg C blank first cycle", 3'b010, 3'b001);
    repeat (2) @(negedge clk);
    check("R6 leg C blank last cycle", 3'b010, 3'b001);
    @(negedge clk);
    check("R6 leg C on after blanking", 3'b110, 3'b001);

    // R7: chopping removes only the high side
    pwm_in = 1'b0;
    @(negedge clk);
    check("R7 pwm low", 3'b000, 3'b001);
    pwm_in = 1'b1;
    @(negedge clk);
    check("R7 pwm high", 3'b110, 3'b001);

    // R8: run low blanks all and freezes the counter
    run_en = 1'b0;
    @(negedge clk);
    check("R8 run low blanks", 3'b000, 3'b000);
    step_once();
    check("R8 step ignored while stopped", 3'b000, 3'b000);
    run_en = 1'b1;
    @(negedge clk);
    check("R8 restart in held sector 2", 3'b110, 3'b001);

    // R6: zero blanking swaps directly
    dead_cycles = 8'd0;
    step_once();
    check("R6 direct swap sector 3", 3'b100, 3'b011);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule